// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit keeps two 24-bit data pointers, a main one and a shadow one, for an 8051-style core. A control register chooses which pointer is active. It also gives each pointer its own update mode, applied after each access. The core reads and writes the active pointer through three byte registers: low, high and page. The full active pointer also leaves the unit as one 24-bit address bus for external and code memory.

The core pulses a strobe once for each finished memory access that used the data pointer as its address. On that strobe the active pointer is incremented, decremented, has its lowest bit flipped, or stays as it is, according to its own mode. If automatic swapping is on, the selection then changes to the other pointer, so the next access uses it. The register bit just above the select bit always reads 0 and is not stored. Adding one to the control register therefore flips only the select bit.

Top module: `dual_dptr`

## Requirements
- R1: After reset the control register reads 00h, both pointers are 000000h, and the low, high and page registers read 00h.
- R2: In the control register at address A7h, bit 7 and bit 1 always read 0 and ignore writes. Bit 6 enables auto-swap, bits 5:4 set the shadow mode, bits 3:2 set the main mode and bit 0 is the select.
- R3: With select 0, `dptr` and the byte registers (low 82h, high 83h, page 84h) show the main pointer. With select 1 they show the shadow pointer.
- R4: A byte write to low, high or page changes only the selected pointer. The other pointer keeps its value.
- R5: Mode 00 leaves the active pointer unchanged on a strobe. With no strobe and no write, both pointers and the select hold their values.
- R6: Mode 01 adds one to the full 24-bit active pointer on a strobe. The carry ripples into the page byte, and FFFFFFh wraps to 000000h.
- R7: Mode 10 subtracts one from the full 24-bit active pointer on a strobe. The borrow ripples, and 000000h wraps to FFFFFFh.
- R8: Mode 11 inverts only bit 0 of the active pointer on a strobe.
- R9: A strobe updates only the active pointer, and it uses that pointer's own mode field.
- R10: With auto-swap set, the select inverts after each strobe. The update from R9 uses the pointer that was active before the swap.
- R11: Writing the value read from the control register plus one flips only the select bit. The mode and auto-swap fields are not changed.
- R12: If a byte write and a strobe fall in the same cycle, the written value is stored without any update, and auto-swap still acts. If a control write and a strobe fall in the same cycle, the pointer is updated under the old modes and the written control value replaces the register, auto-swap included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_we | input | 1 | Register write enable |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr`; 0 for any other address |
| acc_stb | input | 1 | One-cycle pulse per finished access addressed by the data pointer |
| dptr | output | 24 | Active 24-bit pointer |

## Verification
The assertions assume that `acc_stb` is high only for one cycle per access, and only for accesses that took their address from the pointer. The core is expected to decode program-counter or register-addressed accesses itself and never raise the strobe for them. The assertions also assume that `sfr_we` is high at most once per cycle, for a single address. The stimulus raises the strobe only as one-cycle pulses and issues single writes. It combines a strobe with a write only in the two same-cycle cases of R12. It always sets the control register before it relies on a mode.

// File: rtl/dual_dptr.sv
module dual_dptr #(
  parameter logic [7:0] LO_ADDR  = 8'h82,
  parameter logic [7:0] HI_ADDR  = 8'h83,
  parameter logic [7:0] PG_ADDR  = 8'h84,
  parameter logic [7:0] CTL_ADDR = 8'hA7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        acc_stb,
  output logic [23:0] dptr
);
  localparam logic [7:0] CTL_MASK = 8'h7D;

  logic [23:0] main_q, shad_q, act, nxt;
  logic [7:0]  ctl_q;
  logic        wr_lo, wr_hi, wr_pg, wr_ctl, wr_byte;
  logic [1:0]  act_mode;

  assign act      = ctl_q[0] ? shad_q : main_q;
  assign act_mode = ctl_q[0] ? ctl_q[5:4] : ctl_q[3:2];
  assign dptr     = act;

  assign wr_lo   = sfr_we && sfr_addr == LO_ADDR;
  assign wr_hi   = sfr_we && sfr_addr == HI_ADDR;
  assign wr_pg   = sfr_we && sfr_addr == PG_ADDR;
  assign wr_ctl  = sfr_we && sfr_addr == CTL_ADDR;
  assign wr_byte = wr_lo | wr_hi | wr_pg;

  function automatic logic [23:0] post_mod(input logic [23:0] p, input logic [1:0] m);
    case (m)
      2'b01:   return p + 24'd1;
      2'b10:   return p - 24'd1;
      2'b11:   return {p[23:1], ~p[0]};
      default: return p;
    endcase
  endfunction

  always_comb begin
    nxt = act;
    if (wr_byte) begin
      if (wr_lo) nxt[7:0]   = sfr_wdata;
      if (wr_hi) nxt[15:8]  = sfr_wdata;
      if (wr_pg) nxt[23:16] = sfr_wdata;
    end else if (acc_stb) begin
      nxt = post_mod(act, act_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      shad_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (ctl_q[0]) shad_q <= nxt;
      else          main_q <= nxt;
      if (wr_ctl)                 ctl_q    <= sfr_wdata & CTL_MASK;
      else if (acc_stb && ctl_q[6]) ctl_q[0] <= ~ctl_q[0];
    end
  end

  always_comb begin
    case (sfr_addr)
      LO_ADDR:  sfr_rdata = act[7:0];
      HI_ADDR:  sfr_rdata = act[15:8];
      PG_ADDR:  sfr_rdata = act[23:16];
      CTL_ADDR: sfr_rdata = ctl_q;
      default:  sfr_rdata = 8'h00;
    endcase
  end

  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] == 1'b0 && ctl_q[1] == 1'b0);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb && !sfr_we |=> $stable(main_q) && $stable(shad_q) && $stable(ctl_q));

  a_r6_main_increment: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !sfr_we && !ctl_q[0] && ctl_q[3:2] == 2'b01 |=> main_q == $past(main_q) + 24'd1);

  a_r7_shadow_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !sfr_we && ctl_q[0] && ctl_q[5:4] == 2'b10 |=> shad_q == $past(shad_q) - 24'd1);

  a_r9_inactive_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && !ctl_q[0] |=> $stable(shad_q));

  a_r10_auto_swap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb && ctl_q[6] && !wr_ctl |=> ctl_q[0] != $past(ctl_q[0]));
endmodule

// File: tb/tb_dual_dptr.sv
module tb_dual_dptr;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_LO = 8'h82, A_HI = 8'h83, A_PG = 8'h84, A_CTL = 8'hA7;
  localparam int NV = 11;
  // {we, addr, wdata, strobe, expected dptr}
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, A_CTL, 8'h04, 1'b0, 24'h000000},
    {1'b1, A_LO,  8'hFF, 1'b0, 24'h0000FF},
    {1'b1, A_HI,  8'hFF, 1'b0, 24'h00FFFF},
    {1'b0, A_LO,  8'h00, 1'b1, 24'h010000},
    {1'b1, A_CTL, 8'h08, 1'b0, 24'h010000},
    {1'b0, A_LO,  8'h00, 1'b1, 24'h00FFFF},
    {1'b1, A_CTL, 8'h0C, 1'b0, 24'h00FFFF},
    {1'b0, A_LO,  8'h00, 1'b1, 24'h00FFFE},
    {1'b0, A_LO,  8'h00, 1'b1, 24'h00FFFF},
    {1'b1, A_CTL, 8'h00, 1'b0, 24'h00FFFF},
    {1'b0, A_LO,  8'h00, 1'b1, 24'h00FFFF}
  };

  logic clk = 0, rst_n = 0, sfr_we = 0, acc_stb = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic [23:0] dptr;
  int checks = 0, fails = 0;
  bit done = 0;

  dual_dptr dut (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .acc_stb(acc_stb), .dptr(dptr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    sfr_we = we; sfr_addr = a; sfr_wdata = d; acc_stb = s;
    @(posedge clk); #1;
    sfr_we = 0; acc_stb = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a; #1;
    chk(req, {16'h0, sfr_rdata}, {16'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    chk("R1 dptr", dptr, 24'h0);
    rd("R1 ctl", A_CTL, 8'h00);
    rd("R1 lo", A_LO, 8'h00);
    rd("R1 pg", A_PG, 8'h00);
    @(negedge clk); rst_n = 1;
    chk("R1 dptr after release", dptr, 24'h0);

    // R5 R6 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][41], VEC[i][40:33], VEC[i][32:25], VEC[i][24]);
      chk($sformatf("R5/R6/R7/R8 vector %0d", i), dptr, VEC[i][23:0]);
    end

    // R3 R4: shadow selected, writes reach it only
    cyc(1, A_CTL, 8'h01, 0);
    chk("R3 shadow shown", dptr, 24'h0);
    cyc(1, A_PG, 8'h12, 0); cyc(1, A_HI, 8'h34, 0); cyc(1, A_LO, 8'h56, 0);
    chk("R4 shadow written", dptr, 24'h123456);
    rd("R3 hi byte", A_HI, 8'h34);
    rd("R3 pg byte", A_PG, 8'h12);
    cyc(1, A_CTL, 8'h00, 0);
    chk("R4 main untouched", dptr, 24'h00FFFF);
    rd("R3 lo byte main", A_LO, 8'hFF);

    // R6 R7 wrap
    cyc(1, A_PG, 8'hFF, 0);
    cyc(1, A_CTL, 8'h04, 0); cyc(0, A_LO, 0, 1);
    chk("R6 wrap", dptr, 24'h000000);
    cyc(1, A_CTL, 8'h08, 0); cyc(0, A_LO, 0, 1);
    chk("R7 wrap", dptr, 24'hFFFFFF);

    // R9 R10: auto swap, per-pointer modes
    cyc(1, A_CTL, 8'h58, 0);
    cyc(0, A_LO, 0, 1);
    chk("R10 swapped to shadow", dptr, 24'h123456);
    cyc(0, A_LO, 0, 1);
    chk("R9 main decremented before swap", dptr, 24'hFFFFFE);
    cyc(1, A_CTL, 8'h59, 0);
    chk("R9 shadow incremented by own mode", dptr, 24'h123457);
    rd("R10 ctl kept", A_CTL, 8'h59);

    // R2 R11
    cyc(1, A_CTL, 8'hFF, 0);
    rd("R2 unused bits read 0", A_CTL, 8'h7D);
    cyc(1, A_CTL, 8'h7E, 0);
    rd("R11 increment clears select only", A_CTL, 8'h7C);
    cyc(1, A_CTL, 8'h7D, 0);
    rd("R11 increment sets select only", A_CTL, 8'h7D);

    // R12 byte write + strobe
    cyc(1, A_CTL, 8'h44, 0);
    cyc(1, A_LO, 8'h10, 1);
    chk("R12 swap still acts", dptr, 24'h123457);
    cyc(1, A_CTL, 8'h44, 0);
    chk("R12 write wins over update", dptr, 24'hFFFF10);
    // R12 control write + strobe
    cyc(1, A_CTL, 8'h04, 1);
    chk("R12 old mode updates, no swap", dptr, 24'hFFFF11);
    rd("R12 control write stored", A_CTL, 8'h04);

    // R5 idle hold
    repeat (3) @(posedge clk);
    #1 chk("R5 idle hold", dptr, 24'hFFFF11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule